// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table held in memory. Software loads a root register with the base of the top-level directory. A caller then presents a virtual address together with a write flag and a user-mode flag. The walker reads the directory entry through a 32-bit read port with a valid/ready request handshake. That entry either ends the walk as a 4 MiB large page or points to a second-level table, and in the second case the walker reads the table entry as well.

The walker checks the present bit and the access rights of every level it visits. It returns one result: a physical address, a flag marking a large page and the caching attributes of the final page, or else a fault code. The fault code tells a missing mapping apart from a denied access. Only one translation is in flight at a time. A new request is taken only after the caller has consumed the previous result.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and in the cycle after it is released, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: For each accepted request the first read goes to `{root[31:12], 12'h000} + va[31:22]*4`. `mem_req_attr` carries `{root[4], root[3]}`, which is {cache-disable, write-through}. Every memory read matches the walk the requirements describe.
- R3: When the directory entry has present=1 (bit 0) and page-size=0 (bit 7), a second read goes to `{pde[31:12], 12'h000} + va[21:12]*4` with `mem_req_attr = {pde[4], pde[3]}`.
- R4: A present directory entry with bit 7 set ends the walk after one read. A permitted access then returns `rsp_paddr = {pde[31:22], va[21:0]}` with `rsp_large = 1`.
- R5: A permitted two-level walk returns `rsp_paddr = {pte[31:12], va[11:0]}` with `rsp_large = 0`. Table-entry bits 5 and 6 (accessed, dirty) have no effect on the result.
- R6: A directory or table entry with bit 0 clear gives `rsp_fault = 2'b01`. `rsp_fault` is 2'b00 on success and 2'b10 on a denied access. On any fault, `rsp_paddr`, `rsp_large` and `rsp_attr` are zero. A missing directory entry issues no second read.
- R7: A write (`req_write = 1`) succeeds only if bit 1 is set in every entry visited. Otherwise it gives fault 2'b10.
- R8: A user access (`req_user = 1`) succeeds only if bit 2 is set in every entry visited. Otherwise it gives fault 2'b10. A supervisor read ignores bits 1 and 2.
- R9: A not-present table entry reports 2'b01 even when the directory entry above it would deny the access.
- R10: `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready`. The result holds until `rsp_ready`. `req_ready` stays 0 from acceptance until the result is consumed.
- R11: On success `rsp_attr` is `{bit4, bit3}` of the final entry: the directory entry for a large page, the table entry for a small page.
- R12: A root register write affects only requests accepted after it. A walk already accepted keeps the directory address it started with.
- R13: With `mem_req_ready` at 1 and each response arriving one cycle after its request handshake, `rsp_valid` rises 3 clock edges after the accepting edge for a walk that stops at the directory level, and 5 edges after it for a walk that reads both levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| root_we | input | 1 | Write strobe for the root register |
| root_wdata | input | 32 | Root value: directory base [31:12], cache-disable [4], write-through [3] |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request can be accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_req_attr | output | 2 | {cache-disable, write-through} for this read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry word returned by memory |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Caller consumes the result |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 2 | 00 ok, 01 not present, 10 access denied |
| rsp_large | output | 1 | Result comes from a 4 MiB page |
| rsp_attr | output | 2 | {cache-disable, write-through} of the final page |

## Verification
Walks that stop at the directory level, including directory faults, give a result 3 edges after acceptance. Walks that reach the table give it after 5 edges. Each memory read lands one edge after the acceptance or response that caused it. The bench records the cycle count at the falling edge before acceptance and compares it with the count at the first falling edge that shows `rsp_valid`. It samples every port on falling edges only. In runs with a stalling memory or a held-off `rsp_ready` the latency check is skipped, but the bench still compares address, fault, attributes and read order against its own model.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int VA_W       = 32;
  localparam int OFF_W      = 12;
  localparam int IDX_W      = 10;
  localparam int ENT_LG     = 2;
  localparam int LG_OFF_W   = OFF_W + IDX_W;
  localparam int FRAME_W    = VA_W - OFF_W;
  localparam int LG_FRAME_W = VA_W - LG_OFF_W;
  localparam int LEVELS     = 2;

  localparam int B_PRESENT = 0;
  localparam int B_WRITE   = 1;
  localparam int B_USER    = 2;
  localparam int B_WT      = 3;
  localparam int B_CD      = 4;
  localparam int B_ACC     = 5;
  localparam int B_SIZE    = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ_PDE, ST_READ_PTE, ST_DONE, ST_FAULT
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0, FLT_ABSENT = 2'd1, FLT_DENIED = 2'd2
  } fault_e;

  typedef struct packed {
    logic [FRAME_W-1:0] frame;
    logic               big;
    logic               cd;
    logic               wt;
    logic               user_ok;
    logic               write_ok;
    logic               present;
  } pt_entry_t;

  function automatic logic [VA_W-1:0] entry_addr(input logic [FRAME_W-1:0] base,
                                                 input logic [IDX_W-1:0]   idx);
    logic [VA_W-1:0] a;
    a = {base, {OFF_W{1'b0}}};
    return a + VA_W'({idx, {ENT_LG{1'b0}}});
  endfunction

  function automatic logic [VA_W-1:0] small_pa(input logic [FRAME_W-1:0] frame,
                                               input logic [OFF_W-1:0]   off);
    return {frame, off};
  endfunction

  function automatic logic [VA_W-1:0] large_pa(input logic [LG_FRAME_W-1:0] frame,
                                               input logic [LG_OFF_W-1:0]   off);
    return {frame, off};
  endfunction
endpackage

// File: rtl/pt_entry_decode.sv
module pt_entry_decode
  import pt_walker_pkg::*;
(
  input  logic [VA_W-1:0] word,
  output pt_entry_t       ent
);
  // accessed/dirty and spare bits carry no meaning for the walk
  logic unused_bits;
  assign unused_bits = ^{word[OFF_W-1:B_SIZE+1], word[B_SIZE-1:B_ACC]};

  assign ent.frame    = word[VA_W-1:OFF_W];
  assign ent.big      = word[B_SIZE];
  assign ent.cd       = word[B_CD];
  assign ent.wt       = word[B_WT];
  assign ent.user_ok  = word[B_USER];
  assign ent.write_ok = word[B_WRITE];
  assign ent.present  = word[B_PRESENT];
endmodule

// File: rtl/pt_perm_check.sv
module pt_perm_check #(
  parameter int N_LVL = 2
) (
  input  logic             want_write,
  input  logic             want_user,
  input  logic [N_LVL-1:0] lvl_w,
  input  logic [N_LVL-1:0] lvl_u,
  output logic             allow
);
  assign allow = (!want_write || (&lvl_w)) && (!want_user || (&lvl_u));
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walker_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] root_base,
  input  logic [1:0]         root_attr,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_write,
  input  logic               req_user,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [VA_W-1:0]    mem_req_addr,
  output logic [1:0]         mem_req_attr,
  input  logic               mem_rsp_valid,
  input  pt_entry_t          ent,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [VA_W-1:0]    rsp_paddr,
  output logic [1:0]         rsp_fault,
  output logic               rsp_large,
  output logic [1:0]         rsp_attr
);
  walk_state_e          state_q;
  logic                 issued_q;
  logic [LG_OFF_W-1:0]  off_q;
  logic                 wr_q, us_q, pde_w_q, pde_u_q;
  logic [VA_W-1:0]      addr_q, paddr_q;
  logic [1:0]           attr_q, pattr_q;
  fault_e               fault_q;
  logic                 big_q;

  // named events for the assertions
  logic req_fire, mreq_fire, entry_arrive, rsp_fire, in_read, allow;
  logic [LEVELS-1:0] lvl_w, lvl_u;

  assign in_read      = (state_q == ST_READ_PDE) || (state_q == ST_READ_PTE);
  assign req_ready    = (state_q == ST_IDLE);
  assign req_fire     = req_valid && req_ready;
  assign mem_req_valid = in_read && !issued_q;
  assign mreq_fire    = mem_req_valid && mem_req_ready;
  assign entry_arrive = in_read && issued_q && mem_rsp_valid;
  assign rsp_valid    = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign rsp_fire     = rsp_valid && rsp_ready;

  assign mem_req_addr = addr_q;
  assign mem_req_attr = attr_q;
  assign rsp_paddr    = paddr_q;
  assign rsp_fault    = fault_q;
  assign rsp_large    = big_q;
  assign rsp_attr     = pattr_q;

  always_comb begin
    if (state_q == ST_READ_PTE) begin
      lvl_w = {pde_w_q, ent.write_ok};
      lvl_u = {pde_u_q, ent.user_ok};
    end else begin
      lvl_w = {ent.write_ok, 1'b1};
      lvl_u = {ent.user_ok, 1'b1};
    end
  end

  pt_perm_check #(.N_LVL(LEVELS)) u_perm (
    .want_write(wr_q), .want_user(us_q),
    .lvl_w(lvl_w), .lvl_u(lvl_u), .allow(allow)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      issued_q <= 1'b0;
      off_q    <= '0;
      wr_q     <= 1'b0;
      us_q     <= 1'b0;
      pde_w_q  <= 1'b0;
      pde_u_q  <= 1'b0;
      addr_q   <= '0;
      attr_q   <= '0;
      paddr_q  <= '0;
      fault_q  <= FLT_NONE;
      big_q    <= 1'b0;
      pattr_q  <= '0;
    end else begin
      if (mreq_fire)    issued_q <= 1'b1;
      if (entry_arrive) issued_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_fire) begin
          off_q   <= req_vaddr[LG_OFF_W-1:0];
          wr_q    <= req_write;
          us_q    <= req_user;
          addr_q  <= entry_addr(root_base, req_vaddr[VA_W-1 -: IDX_W]);
          attr_q  <= root_attr;
          state_q <= ST_READ_PDE;
        end
        ST_READ_PDE: if (entry_arrive) begin
          if (!ent.present) begin
            fault_q <= FLT_ABSENT; paddr_q <= '0; big_q <= 1'b0; pattr_q <= '0;
            state_q <= ST_FAULT;
          end else if (ent.big) begin
            if (allow) begin
              fault_q <= FLT_NONE;
              paddr_q <= large_pa(ent.frame[FRAME_W-1 -: LG_FRAME_W], off_q);
              big_q   <= 1'b1;
              pattr_q <= {ent.cd, ent.wt};
              state_q <= ST_DONE;
            end else begin
              fault_q <= FLT_DENIED; paddr_q <= '0; big_q <= 1'b0; pattr_q <= '0;
              state_q <= ST_FAULT;
            end
          end else begin
            pde_w_q <= ent.write_ok;
            pde_u_q <= ent.user_ok;
            addr_q  <= entry_addr(ent.frame, off_q[LG_OFF_W-1 -: IDX_W]);
            attr_q  <= {ent.cd, ent.wt};
            state_q <= ST_READ_PTE;
          end
        end
        ST_READ_PTE: if (entry_arrive) begin
          if (!ent.present) begin
            fault_q <= FLT_ABSENT; paddr_q <= '0; big_q <= 1'b0; pattr_q <= '0;
            state_q <= ST_FAULT;
          end else if (allow) begin
            fault_q <= FLT_NONE;
            paddr_q <= small_pa(ent.frame, off_q[OFF_W-1:0]);
            big_q   <= 1'b0;
            pattr_q <= {ent.cd, ent.wt};
            state_q <= ST_DONE;
          end else begin
            fault_q <= FLT_DENIED; paddr_q <= '0; big_q <= 1'b0; pattr_q <= '0;
            state_q <= ST_FAULT;
          end
        end
        ST_DONE, ST_FAULT: if (rsp_fire) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_attr)));
  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_attr)));
  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready);
  // R4
  large_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_large) |-> (rsp_paddr[LG_OFF_W-1:0] == off_q));
  // R4
  large_one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ_PDE && entry_arrive && ent.present && ent.big) |=> !mem_req_valid);
  // R6
  absent_pde_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ_PDE && entry_arrive && !ent.present) |=> (rsp_valid && rsp_fault == FLT_ABSENT));
  // R6
  fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_paddr == '0 && !rsp_large && rsp_attr == 2'b00));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            root_we,
  input  logic [VA_W-1:0] root_wdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_write,
  input  logic            req_user,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [VA_W-1:0] mem_req_addr,
  output logic [1:0]      mem_req_attr,
  input  logic            mem_rsp_valid,
  input  logic [VA_W-1:0] mem_rsp_data,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [VA_W-1:0] rsp_paddr,
  output logic [1:0]      rsp_fault,
  output logic            rsp_large,
  output logic [1:0]      rsp_attr
);
  logic [FRAME_W-1:0] root_base_q;
  logic [1:0]         root_attr_q;
  pt_entry_t          ent;

  logic unused_root;
  assign unused_root = ^{root_wdata[OFF_W-1:B_CD+1], root_wdata[B_WT-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      root_base_q <= '0;
      root_attr_q <= '0;
    end else if (root_we) begin
      root_base_q <= root_wdata[VA_W-1:OFF_W];
      root_attr_q <= {root_wdata[B_CD], root_wdata[B_WT]};
    end
  end

  pt_entry_decode u_dec (.word(mem_rsp_data), .ent(ent));

  pt_walk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .root_base(root_base_q), .root_attr(root_attr_q),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_attr(mem_req_attr),
    .mem_rsp_valid(mem_rsp_valid), .ent(ent),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_large(rsp_large), .rsp_attr(rsp_attr)
  );

  // R12
  root_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    root_we |=> (root_base_q == $past(root_wdata[VA_W-1:OFF_W])));
endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        root_we = 1'b0;
  logic [31:0] root_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic [1:0]  mem_req_attr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        rsp_large;
  logic [1:0]  rsp_attr;

  pt_walker uut (.*);

  always #4 clk = ~clk;

  typedef struct packed {
    logic [31:0] pa;
    logic [1:0]  fault;
    logic        big;
    logic [1:0]  attr;
    int          lat;
  } exp_t;
  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  attr;
  } rd_t;

  exp_t  exp_q[$];
  string tag_q[$];
  rd_t   rd_q[$];
  string rdtag_q[$];

  int total = 0, bad = 0, cyc = 0, acc_cyc = 0;
  logic seen = 1'b0, finished = 1'b0, stall_en = 1'b0;
  logic hs_n = 1'b0;
  logic [31:0] data_n = '0;
  logic [31:0] root_sh = '0;
  logic [31:0] mem [0:4095];

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] memrd(input logic [31:0] a);
    return (a[31:14] == 0) ? mem[a[13:2]] : 32'h0;
  endfunction

  function automatic logic [31:0] mk(input int d, input int j, input int o);
    return (32'(d) << 22) | (32'(j) << 12) | 32'(o);
  endfunction

  // memory model and read-port monitor
  always @(negedge clk) begin
    hs_n = mem_req_valid && mem_req_ready;
    if (hs_n) begin
      data_n = memrd(mem_req_addr);
      if (rd_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R2 unexpected read actual=%h expected=none", mem_req_addr);
      end else begin
        chk(rdtag_q[0], "read address", mem_req_addr, rd_q[0].addr);
        chk(rdtag_q[0], "read attr", 32'(mem_req_attr), 32'(rd_q[0].attr));
        void'(rd_q.pop_front());
        void'(rdtag_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= hs_n;
    mem_rsp_data  <= data_n;
    mem_req_ready <= stall_en ? ~mem_req_ready : 1'b1;
  end

  // result monitor
  always @(negedge clk) begin
    if (rsp_valid && !seen && exp_q.size() > 0) begin
      seen = 1'b1;
      if (exp_q[0].lat >= 0)
        chk("R13", "latency", 32'(cyc - acc_cyc), 32'(exp_q[0].lat));
    end
    if (rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R10 unexpected result actual=%h expected=none", rsp_paddr);
      end else begin
        chk(tag_q[0], "paddr", rsp_paddr, exp_q[0].pa);
        chk(tag_q[0], "fault", 32'(rsp_fault), 32'(exp_q[0].fault));
        chk(tag_q[0], "large", 32'(rsp_large), 32'(exp_q[0].big));
        chk(tag_q[0], "attr", 32'(rsp_attr), 32'(exp_q[0].attr));
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
      seen = 1'b0;
    end
  end

  task automatic push_rd(input logic [31:0] a, input logic [1:0] at, input string t);
    rd_t r;
    r.addr = a; r.attr = at;
    rd_q.push_back(r);
    rdtag_q.push_back(t);
  endtask

  // driver: computes expectations from the bench's own walk model
  task automatic launch(input logic [31:0] va, input logic wr, input logic us,
                        input string tag, input logic timed);
    exp_t e;
    logic [31:0] a1, a2, pde, pte;
    a1 = (root_sh & 32'hFFFF_F000) + ((va >> 22) << 2);
    push_rd(a1, {root_sh[4], root_sh[3]}, "R2");
    pde = memrd(a1);
    e.pa = '0; e.fault = 2'd0; e.big = 1'b0; e.attr = 2'b00; e.lat = 3;
    if (!pde[0]) e.fault = 2'd1;
    else if (pde[7]) begin
      if ((!wr || pde[1]) && (!us || pde[2])) begin
        e.pa = (pde & 32'hFFC0_0000) | (va & 32'h003F_FFFF);
        e.big = 1'b1;
        e.attr = {pde[4], pde[3]};
      end else e.fault = 2'd2;
    end else begin
      a2 = (pde & 32'hFFFF_F000) + (((va >> 12) & 32'h3FF) << 2);
      push_rd(a2, {pde[4], pde[3]}, "R3");
      pte = memrd(a2);
      e.lat = 5;
      if (!pte[0]) e.fault = 2'd1;
      else if ((!wr || (pde[1] && pte[1])) && (!us || (pde[2] && pte[2]))) begin
        e.pa = (pte & 32'hFFFF_F000) | (va & 32'h0000_0FFF);
        e.attr = {pte[4], pte[3]};
      end else e.fault = 2'd2;
    end
    if (!timed) e.lat = -1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_user = us; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    acc_cyc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || rd_q.size() != 0) @(negedge clk);
  endtask

  task automatic run(input logic [31:0] va, input logic wr, input logic us, input string tag);
    launch(va, wr, us, tag, 1'b1);
    wait_idle();
  endtask

  task automatic write_root(input logic [31:0] v);
    @(negedge clk);
    root_we = 1'b1; root_wdata = v;
    @(negedge clk);
    root_we = 1'b0;
    root_sh = v;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    // directory at 0x1000
    mem[12'h400] = 32'h0000_2017;  // table at 0x2000, P RW US CD
    mem[12'h401] = 32'hA940_008F;  // large, P RW US WT
    mem[12'h402] = 32'h0000_3006;  // not present
    mem[12'h403] = 32'h0000_3001;  // table at 0x3000, supervisor read-only
    mem[12'h404] = 32'h1240_0091;  // large, supervisor read-only, CD
    mem[12'h405] = 32'h0000_3007;  // table at 0x3000, full rights
    // table at 0x2000
    mem[12'h800] = 32'h1234_5007;
    mem[12'h801] = 32'h5678_9003;
    mem[12'h802] = 32'h0000_0000;
    mem[12'h803] = 32'hCAFE_F01F;
    mem[12'h804] = 32'h0BAD_0005;
    // table at 0x3000
    mem[12'hC00] = 32'h7777_7007;
    mem[12'hC01] = 32'h0000_0000;
    mem[12'hC02] = 32'h4444_4067;  // accessed and dirty set
    // second directory at 0x0000
    mem[12'h000] = 32'h8000_0083;

    repeat (3) @(negedge clk);
    chk("R1", "req_ready in reset", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "req_ready", 32'(req_ready), 32'd1);
    chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1", "mem_req_valid", 32'(mem_req_valid), 32'd0);

    write_root(32'h0000_1008);
    run(mk(0, 0, 12'h123), 1'b0, 1'b0, "R5");
    run(mk(1, 0, 0) | 32'h0002_3456, 1'b1, 1'b1, "R4");
    run(mk(2, 0, 4), 1'b0, 1'b0, "R6");
    run(mk(0, 2, 8), 1'b0, 1'b0, "R6");
    run(mk(0, 1, 12'h010), 1'b0, 1'b1, "R8");
    run(mk(0, 1, 12'h010), 1'b1, 1'b0, "R8");
    run(mk(0, 4, 0), 1'b1, 1'b0, "R7");
    run(mk(0, 4, 0), 1'b0, 1'b1, "R7");
    run(mk(3, 0, 12'h044), 1'b1, 1'b0, "R7");
    run(mk(3, 0, 12'h044), 1'b0, 1'b1, "R8");
    run(mk(3, 0, 12'h044), 1'b0, 1'b0, "R8");
    run(mk(3, 1, 0), 1'b1, 1'b1, "R9");
    run(mk(4, 12'h155, 12'h777), 1'b1, 1'b0, "R7");
    run(mk(4, 12'h155, 12'h777), 1'b0, 1'b0, "R11");
    run(mk(0, 3, 12'hABC), 1'b1, 1'b1, "R11");
    run(mk(5, 2, 12'hFFF), 1'b1, 1'b1, "R5");

    // held-off result consumer
    @(posedge clk); #1 rsp_ready = 1'b0;
    launch(mk(0, 0, 12'hFFF), 1'b0, 1'b0, "R10", 1'b1);
    repeat (8) @(negedge clk);
    chk("R10", "rsp_valid held", 32'(rsp_valid), 32'd1);
    chk("R10", "req_ready while busy", 32'(req_ready), 32'd0);
    @(posedge clk); #1 rsp_ready = 1'b1;
    wait_idle();

    // stalling memory, root rewritten mid-walk
    stall_en = 1'b1;
    launch(mk(5, 0, 12'h05A), 1'b1, 1'b1, "R12", 1'b0);
    write_root(32'h0000_0010);
    wait_idle();
    stall_en = 1'b0;
    repeat (2) @(negedge clk);
    run(32'h0012_3456, 1'b0, 1'b0, "R12");

    repeat (4) @(negedge clk);
    chk("R10", "no stray reads", 32'(rd_q.size()), 32'd0);
    finished = 1'b1;
    finish_run();
  end
endmodule